// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar and raises an alarm when the time reaches a programmed minute. It holds four alarm registers: minute, hour, day of month and weekday. Each one can be left out of the comparison on its own. The calendar counter supplies the live time as BCD fields, and software programs the alarm through a simple byte-wide register port.

The alarm has one-minute resolution. The comparison is made only when the seconds field wraps to 00. At that moment, if every field that takes part matches, a sticky alarm flag is set. When the alarm interrupt is enabled, an active-low interrupt pin stays low until software clears the flag. Counting the time and the serial bus that carries register traffic both sit outside this block.

Register layout, as seen on the register port:
- Address 0x1 is the control register. Bit 3 is the alarm flag and bit 1 is the interrupt enable. All other bits read as 0.
- Addresses 0x9, 0xA, 0xB and 0xC hold the alarm minute, hour, day and weekday.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset the alarm flag and the interrupt enable are 0, and alarmIrqN is 1. The control register reads 0x00. All four alarm registers read 0x80, which means every field is excluded.
- R2: A write to an alarm register at 0x9–0xC stores the full byte and reads back unchanged. The control register at 0x1 reads with the flag in bit 3 and the enable in bit 1; its other bits always read 0.
- R3: Matching is evaluated only in the cycle where curSec is 0x00 and it was nonzero in the previous cycle. A match that persists while seconds stay at 00 sets the flag only once; it sets it again only at the next wrap.
- R4: Only the masked value bits take part in each comparison. Minute uses bits 6:0, hour bits 5:0, day bits 5:0 and weekday bits 2:0. Alarm bits between the mask and bit 7 are ignored.
- R5: When bit 7 of an alarm register is 1, that field is excluded and counts as matching.
- R6: When bit 7 is 1 in all four alarm registers, the flag is never set.
- R7: A match sets the flag even while the interrupt enable is 0. In that case alarmIrqN stays 1.
- R8: alarmIrqN is 0 exactly while the flag and the enable are both 1. It stays 0 until software clears the flag or the enable.
- R9: Writing the control register loads the enable from bit 1. If bit 3 of the written byte is 0, the flag clears. If bit 3 is 1, the flag is left as it was.
- R10: If a match and a flag-clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curSec | input | 7 | Live seconds, BCD |
| curMin | input | 7 | Live minutes, BCD |
| curHour | input | 6 | Live hours, BCD |
| curDay | input | 6 | Live day of month, BCD |
| curWday | input | 3 | Live weekday |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| alarmIrqN | output | 1 | Active-low alarm interrupt level |

## Verification
The hardest situations to reach are the ones that depend on the seconds wrap.

The first is a match that stays true while seconds remain at 00. The bench holds curSec at 00 for several cycles after clearing the flag, to show that no second set happens.

The second is a hit that lands in the same cycle as a clearing write. The bench places the control write in exactly the wrap cycle.

The sweep covers all sixteen disable patterns against all sixteen per-field mismatch patterns, each driven through a full 59-to-00 wrap.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int SEC_W      = 7;
  localparam int MIN_W      = 7;
  localparam int HOUR_W     = 6;
  localparam int DAY_W      = 6;
  localparam int WDAY_W     = 3;
  localparam int REG_W      = 8;
  localparam int DIS_BIT    = 7;
  localparam int FLAG_BIT   = 3;
  localparam int IE_BIT     = 1;

  // Strobes from the datapath to the control
  typedef struct packed {
    logic hitPulse;
    logic ctlWrite;
    logic wrFlagBit;
    logic wrIeBit;
  } dpStrobe_t;

  // State returned from the control to the datapath, used for readback
  typedef struct packed {
    logic flag;
    logic irqEn;
  } ctlState_t;

  function automatic logic [REG_W-1:0] fieldMask(input int idx);
    case (idx)
      0:       return REG_W'((1 << MIN_W) - 1);
      1:       return REG_W'((1 << HOUR_W) - 1);
      2:       return REG_W'((1 << DAY_W) - 1);
      default: return REG_W'((1 << WDAY_W) - 1);
    endcase
  endfunction
endpackage

// File: rtl/alarm_cmp_datapath.sv
module alarm_cmp_datapath
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 1,
  parameter int ALM_BASE = 9,
  parameter logic [REG_W-1:0] ALM_RST = 8'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEC_W-1:0]           curSec,
  input  logic [MIN_W-1:0]           curMin,
  input  logic [HOUR_W-1:0]          curHour,
  input  logic [DAY_W-1:0]           curDay,
  input  logic [WDAY_W-1:0]          curWday,
  input  logic                       regWe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [REG_W-1:0]           regWrData,
  output logic [REG_W-1:0]           regRdData,
  input  ctlState_t                  ctlView,
  output dpStrobe_t                  dpStb,
  output logic [NUM_FIELDS-1:0]      almDis
);
  logic [NUM_FIELDS-1:0][REG_W-1:0] almReg;
  logic [NUM_FIELDS-1:0][REG_W-1:0] curField;
  logic [NUM_FIELDS-1:0]            fieldOk;
  logic [SEC_W-1:0]                 prevSec;
  logic                             minuteEdge;
  logic                             anyArmed;

  assign curField[0] = REG_W'(curMin);
  assign curField[1] = REG_W'(curHour);
  assign curField[2] = REG_W'(curDay);
  assign curField[3] = REG_W'(curWday);

  // Alarm register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FIELDS; i++) almReg[i] <= ALM_RST;
    end else if (regWe) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (regAddr == ADDR_W'(ALM_BASE + i)) almReg[i] <= regWrData;
    end
  end

  // Seconds history for minute wrap detection
  always_ff @(posedge clk) begin
    if (!rstN) prevSec <= '0;
    else       prevSec <= curSec;
  end

  assign minuteEdge = (curSec == '0) && (prevSec != '0);

  // Per-field comparison, masked value bits only
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gCmp
    localparam logic [REG_W-1:0] M = fieldMask(g);
    assign almDis[g]  = almReg[g][DIS_BIT];
    assign fieldOk[g] = almDis[g] | ((almReg[g] & M) == (curField[g] & M));
  end

  assign anyArmed = ~&almDis;

  always_comb begin
    dpStb.hitPulse  = minuteEdge & anyArmed & (&fieldOk);
    dpStb.ctlWrite  = regWe && (regAddr == ADDR_W'(CTL_ADDR));
    dpStb.wrFlagBit = regWrData[FLAG_BIT];
    dpStb.wrIeBit   = regWrData[IE_BIT];
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CTL_ADDR)) begin
      regRdData[FLAG_BIT] = ctlView.flag;
      regRdData[IE_BIT]   = ctlView.irqEn;
    end
    for (int i = 0; i < NUM_FIELDS; i++)
      if (regAddr == ADDR_W'(ALM_BASE + i)) regRdData = almReg[i];
  end
endmodule

// File: rtl/alarm_cmp_control.sv
module alarm_cmp_control
  import alarm_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t dpStb,
  output ctlState_t ctlView,
  output logic      alarmIrqN
);
  logic flagQ;
  logic ieQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      ieQ   <= 1'b0;
    end else begin
      if (dpStb.ctlWrite) ieQ <= dpStb.wrIeBit;
      // A new hit outranks a clearing write in the same cycle
      if (dpStb.hitPulse)                             flagQ <= 1'b1;
      else if (dpStb.ctlWrite && !dpStb.wrFlagBit)    flagQ <= 1'b0;
    end
  end

  assign ctlView.flag  = flagQ;
  assign ctlView.irqEn = ieQ;
  assign alarmIrqN     = ~(flagQ & ieQ);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 1,
  parameter int ALM_BASE = 9,
  parameter logic [7:0] ALM_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        curSec,
  input  logic [6:0]        curMin,
  input  logic [5:0]        curHour,
  input  logic [5:0]        curDay,
  input  logic [2:0]        curWday,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              alarmIrqN
);
  dpStrobe_t             dpStb;
  ctlState_t             ctlView;
  logic [NUM_FIELDS-1:0] almDis;

  alarm_cmp_datapath #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .ALM_BASE(ALM_BASE), .ALM_RST(ALM_RST)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curWday(curWday),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctlView(ctlView), .dpStb(dpStb), .almDis(almDis)
  );

  alarm_cmp_control uCtl (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .ctlView(ctlView), .alarmIrqN(alarmIrqN)
  );
endmodule

// File: rtl/alarm_cmp_checker.sv
module alarm_cmp_checker #(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [6:0]        curSec,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrFlagBit,
  input logic              alarmIrqN,
  input logic              hitPulse,
  input logic              flag,
  input logic [3:0]        almDis
);
  logic ctlWr;
  assign ctlWr = regWe && (regAddr == ADDR_W'(CTL_ADDR));

  // R3
  hit_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> (curSec == 7'd0 && $past(curSec) != 7'd0));

  // R6
  all_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&almDis) |-> !hitPulse);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !wrFlagBit && !hitPulse) |=> !flag);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrFlagBit && !hitPulse) |=> $stable(flag));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |=> flag);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmIrqN && !ctlWr) |=> !alarmIrqN);
endmodule

bind alarm_cmp_top alarm_cmp_checker #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .curSec(curSec), .regWe(regWe), .regAddr(regAddr),
  .wrFlagBit(regWrData[3]), .alarmIrqN(alarmIrqN), .hitPulse(dpStb.hitPulse),
  .flag(ctlView.flag), .almDis(almDis)
);

// File: tb/tb_alarm_cmp_top.sv
`timescale 1ns/1ps
module tb_alarm_cmp_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] curSec;
  logic [6:0] curMin;
  logic [5:0] curHour;
  logic [5:0] curDay;
  logic [2:0] curWday;
  logic       regWe;
  logic [3:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       alarmIrqN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [3:0] A_CTL = 4'h1;
  localparam logic [3:0] A_MIN = 4'h9;
  localparam logic [3:0] A_HR  = 4'hA;
  localparam logic [3:0] A_DAY = 4'hB;
  localparam logic [3:0] A_WD  = 4'hC;

  always #5 clk = ~clk;

  alarm_cmp_top dut (
    .clk(clk), .rstN(rstN), .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curWday(curWday), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .alarmIrqN(alarmIrqN)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  // Seconds 59 then 00; returns at the negedge after the wrap edge
  task automatic wrapMinute();
    @(negedge clk); curSec = 7'h59;
    @(negedge clk); curSec = 7'h00;
    @(negedge clk);
  endtask

  task automatic setTime(input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [2:0] w);
    curMin = m; curHour = h; curDay = d; curWday = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWrData = '0;
    curSec = 7'h01;
    setTime(7'h45, 6'h12, 6'h27, 3'd3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", alarmIrqN, 1);
    rd(A_CTL, v); chk("R1 ctl", v, 8'h00);
    rd(A_MIN, v); chk("R1 min", v, 8'h80);
    rd(A_HR, v);  chk("R1 hour", v, 8'h80);
    rd(A_DAY, v); chk("R1 day", v, 8'h80);
    rd(A_WD, v);  chk("R1 wday", v, 8'h80);
    wrapMinute();
    rd(A_CTL, v); chk("R6 reset-disabled no fire", v, 8'h00);

    // R2 readback
    wr(A_CTL, 8'hFF);
    rd(A_CTL, v); chk("R2 ctl other bits zero", v, 8'h02);
    wr(A_CTL, 8'h00);
    wr(A_MIN, 8'h5A); rd(A_MIN, v); chk("R2 min", v, 8'h5A);
    wr(A_WD, 8'hC6);  rd(A_WD, v);  chk("R2 wday", v, 8'hC6);

    // R4 R5 R6 R7: sweep disable patterns against mismatch patterns
    for (int dis = 0; dis < 16; dis++) begin
      wr(A_MIN, {dis[0], 7'h45});
      wr(A_HR,  {dis[1], 7'h12});
      wr(A_DAY, {dis[2], 7'h27});
      wr(A_WD,  {dis[3], 7'h03});
      for (int mm = 0; mm < 16; mm++) begin
        logic [3:0] disV;
        logic [3:0] mmV;
        bit expF;
        disV = 4'(dis);
        mmV  = 4'(mm);
        wr(A_CTL, 8'h00);
        setTime(mmV[0] ? 7'h44 : 7'h45, mmV[1] ? 6'h13 : 6'h12,
                mmV[2] ? 6'h07 : 6'h27, mmV[3] ? 3'd5 : 3'd3);
        wrapMinute();
        expF = (disV != 4'hF) && ((~disV & mmV) == 4'h0);
        rd(A_CTL, v);
        chk("R4 R5 R6 R7 sweep flag", int'(v[3]), int'(expF));
        chk("R7 irq idle with enable off", alarmIrqN, 1);
        curSec = 7'h01;
      end
    end

    // R4 ignored alarm bits above the mask
    setTime(7'h45, 6'h12, 6'h27, 3'd3);
    wr(A_MIN, 8'h45); wr(A_HR, 8'h52); wr(A_DAY, 8'h67); wr(A_WD, 8'h7B);
    wr(A_CTL, 8'h02);
    wrapMinute();
    rd(A_CTL, v); chk("R4 masked match flag", v, 8'h0A);
    chk("R8 irq low", alarmIrqN, 0);

    // R8 held while seconds move on
    curSec = 7'h01;
    repeat (5) @(negedge clk);
    chk("R8 irq held", alarmIrqN, 0);

    // R9 write 1 to flag keeps it
    wr(A_CTL, 8'h0A);
    rd(A_CTL, v); chk("R9 write one keeps flag", v, 8'h0A);
    // R8 disable enable -> pin released, flag kept
    wr(A_CTL, 8'h08);
    chk("R8 irq released by enable", alarmIrqN, 1);
    rd(A_CTL, v); chk("R9 flag kept ie cleared", v, 8'h08);
    wr(A_CTL, 8'h0A);
    chk("R8 irq back", alarmIrqN, 0);
    // R9 clear
    wr(A_CTL, 8'h02);
    chk("R9 clear releases irq", alarmIrqN, 1);
    rd(A_CTL, v); chk("R9 flag cleared", v, 8'h02);

    // R3 persistent match inside one minute sets only once
    wrapMinute();
    rd(A_CTL, v); chk("R3 first set", v, 8'h0A);
    wr(A_CTL, 8'h02);
    repeat (6) @(negedge clk);
    rd(A_CTL, v); chk("R3 no re-set while seconds stay 00", v, 8'h02);
    curSec = 7'h01;
    @(negedge clk);
    rd(A_CTL, v); chk("R3 no set on nonzero seconds", v, 8'h02);
    curSec = 7'h00;
    @(negedge clk);
    rd(A_CTL, v); chk("R3 set on wrap from 01", v, 8'h0A);

    // R10 clearing write in the wrap cycle
    @(negedge clk); curSec = 7'h30;
    @(negedge clk); curSec = 7'h00;
    regWe = 1'b1; regAddr = A_CTL; regWrData = 8'h02;
    @(negedge clk); regWe = 1'b0;
    rd(A_CTL, v); chk("R10 set wins over clear", v, 8'h0A);
    chk("R10 irq low", alarmIrqN, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule